// File: doc/BRIEF.md
# Nested-Virtualization Register Access Redirector

This block owns one hypervisor-level system register, the page base used for redirected register traffic, and decides how each access to that register is handled. A system-register request arrives with its five encoding fields, a read/write flag and write data. The block weighs it against the current exception level, an EL2-enabled flag, two nested-virtualization control bits (`ctl_nv`, `ctl_nv2`) and a flag that says whether the EL2 virtual address space is wider than 48 bits.

Each accepted request ends in exactly one of four results:
- a direct completion, where the held register is read or written;
- a 64-bit load or store on a simple memory port;
- a trap to the hypervisor, with a 6-bit syndrome class;
- an undefined-instruction report.

The memory address for a redirected access is the stored page base joined with a fixed 12-bit offset, sign-extended according to the address-space width.

The controller is a three-state machine:
- **IDLE** accepts a request. A matching request whose route is direct, trap or undefined takes the **IDLE→RESP** transition. A redirected request takes **IDLE→MEM**.
- **RESP** presents the result for one cycle and then always takes **RESP→IDLE**.
- **MEM** drives the memory request. It stays in MEM until `mem_ack`, then takes **MEM→IDLE**. The completion is reported in the acknowledge cycle.

Top module: `nvreg_redirect`

## Requirements
- R1: Only the encoding op0=0b11, op1=0b100, CRn=0b0010, CRm=0b0010, op2=0b000 is acted on. A request with any other encoding produces no result and leaves the held register unchanged.
- R2: A matching request accepted at exception level 0 (`cur_el`=0) raises `res_undef` in the cycle after acceptance.
- R3: At level 1, with `el2_en`=1, `ctl_nv`=1 and `ctl_nv2`=1, the request becomes a memory access. From the cycle after acceptance, `mem_valid`=1, `mem_write` equals the request's write flag, and `mem_wdata` equals its write data.
- R4: At level 1, with `el2_en`=1, `ctl_nv`=1 and `ctl_nv2`=0, the request raises `res_trap` in the cycle after acceptance, with `res_class`=0x18.
- R5: At level 1 in every other combination (EL2 disabled, or `ctl_nv`=0), the request raises `res_undef` in the cycle after acceptance.
- R6: At levels 2 and 3, the request raises `res_done` in the cycle after acceptance. A write updates the held register at the accepting edge. A read returns the register on `res_rdata`.
- R7: Readback returns bits 63:12 exactly as written, and bits 11:0 as zero.
- R8: `mem_addr` bits 11:0 equal 0x0B0. With `va_wide`=0, bits 63:12 are the stored bits 48:12, sign-extended from bit 48. With `va_wide`=1, bits 63:12 are the stored bits 52:12, sign-extended from bit 52.
- R9: A memory request holds its address, data and direction until `mem_ack`. In the acknowledge cycle, `res_mem`=1 and `res_rdata` equals `mem_rdata`. `mem_valid` is low in the next cycle.
- R10: At most one of `res_done`, `res_mem`, `res_trap`, `res_undef` is high at a time, and each accepted request yields exactly one pulse. `res_class` is 0x18 with `res_trap` and 0 otherwise.
- R11: After reset, `req_ready`=1, no result or memory request is active, and the held register reads as zero.
- R12: `req_ready` is low while a request is in progress. Requests presented then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 = write form, 0 = read form |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level |
| el2_en | input | 1 | EL2 enabled in the current security state |
| ctl_nv | input | 1 | Nested-virtualization enable bit |
| ctl_nv2 | input | 1 | Nested-virtualization redirect bit |
| va_wide | input | 1 | EL2 address space wider than 48 bits |
| res_done | output | 1 | Direct completion pulse |
| res_mem | output | 1 | Redirected access completion pulse |
| res_trap | output | 1 | Trap-to-hypervisor pulse |
| res_undef | output | 1 | Undefined-instruction pulse |
| res_class | output | 6 | Syndrome class, valid with res_trap |
| res_rdata | output | 64 | Read data for direct and redirected reads |
| mem_valid | output | 1 | Memory request active |
| mem_write | output | 1 | Memory request is a store |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 64 | Store data |
| mem_ack | input | 1 | Memory request completed |
| mem_rdata | input | 64 | Load data, valid with mem_ack |

## Verification
The bench checks the level-1 routing combinations one by one:
- NV2 set with NV clear must give undefined, not a redirect.
- A disabled EL2 must give undefined, not a trap.

A design that tested NV2 alone, or ignored the enable, would emit the wrong pulse.

Two stored bases are chosen so that bit 48 and bit 52 disagree. A design that sign-extended from the wrong bit, or ignored `va_wide`, would emit an address with the wrong top bits.

Further corners:
- A mismatched encoding is presented.
- A direct write arrives while a load is waiting for its acknowledge.
- The acknowledge is given in the same cycle as the request, and also after a delay.

A design that decoded loosely, accepted requests while busy, or completed early would corrupt the later readback or raise a stray pulse.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

    typedef enum logic [1:0] {
        RT_DIRECT,
        RT_MEM,
        RT_TRAP,
        RT_UNDEF
    } route_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESP,
        ST_MEM
    } state_t;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    localparam sysenc_t ENC_BASE_REG = '{op0: 2'b11, op1: 3'b100, crn: 4'b0010,
                                         crm: 4'b0010, op2: 3'b000};

    localparam logic [1:0] LVL_USER  = 2'd0;
    localparam logic [1:0] LVL_GUEST = 2'd1;

endpackage

// File: rtl/nvr_decode.sv
module nvr_decode
    import nvr_pkg::*;
#(
    parameter sysenc_t MATCH_ENC = ENC_BASE_REG
) (
    input  sysenc_t    enc_i,
    input  logic [1:0] el_i,
    input  logic       el2_en_i,
    input  logic       nv_i,
    input  logic       nv2_i,
    output logic       hit_o,
    output route_t     route_o
);

    assign hit_o = (enc_i == MATCH_ENC);

    always_comb begin
        route_o = RT_UNDEF;
        if (el_i == LVL_USER) begin
            route_o = RT_UNDEF;
        end else if (el_i == LVL_GUEST) begin
            if (el2_en_i && nv_i && nv2_i) begin
                route_o = RT_MEM;
            end else if (el2_en_i && nv_i) begin
                route_o = RT_TRAP;
            end else begin
                route_o = RT_UNDEF;
            end
        end else begin
            route_o = RT_DIRECT;
        end
    end

endmodule

// File: rtl/nvr_basereg.sv
module nvr_basereg #(
    parameter int              XLEN       = 64,
    parameter int              PAGE_BITS  = 12,
    parameter int              NARROW_MSB = 48,
    parameter int              WIDE_MSB   = 52,
    parameter logic [PAGE_BITS-1:0] OFFSET = 12'h0B0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [XLEN-PAGE_BITS-1:0] wr_base_i,
    input  logic                      va_wide_i,
    output logic [XLEN-1:0]           readback_o,
    output logic [XLEN-1:0]           addr_o
);

    localparam int BASE_W = XLEN - PAGE_BITS;
    localparam int N_IDX  = NARROW_MSB - PAGE_BITS;
    localparam int W_IDX  = WIDE_MSB - PAGE_BITS;

    logic [BASE_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en_i) begin
            base_q <= wr_base_i;
        end
    end

    assign readback_o = {base_q, {PAGE_BITS{1'b0}}};
    assign addr_o[PAGE_BITS-1:0] = OFFSET;

    for (genvar b = PAGE_BITS; b < XLEN; b++) begin : g_abit
        if (b <= NARROW_MSB) begin : g_low
            assign addr_o[b] = base_q[b-PAGE_BITS];
        end else if (b <= WIDE_MSB) begin : g_mid
            assign addr_o[b] = va_wide_i ? base_q[b-PAGE_BITS] : base_q[N_IDX];
        end else begin : g_top
            assign addr_o[b] = va_wide_i ? base_q[W_IDX] : base_q[N_IDX];
        end
    end

endmodule

// File: rtl/nvr_ctrl.sv
module nvr_ctrl
    import nvr_pkg::*;
#(
    parameter int         XLEN       = 64,
    parameter int         CLASS_W    = 6,
    parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire_i,
    input  route_t             route_i,
    input  logic               write_i,
    input  logic [XLEN-1:0]    wdata_i,
    input  logic [XLEN-1:0]    readback_i,
    input  logic               mem_ack_i,
    input  logic [XLEN-1:0]    mem_rdata_i,
    output logic               ready_o,
    output logic               reg_wr_o,
    output logic               done_o,
    output logic               mem_done_o,
    output logic               trap_o,
    output logic               undef_o,
    output logic [CLASS_W-1:0] class_o,
    output logic [XLEN-1:0]    rdata_o,
    output logic               mem_valid_o,
    output logic               mem_write_o,
    output logic [XLEN-1:0]    mem_wdata_o
);

    state_t          state_q, state_d;
    route_t          kind_q;
    logic            write_q;
    logic [XLEN-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= RT_UNDEF;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && fire_i) begin
                kind_q  <= route_i;
                write_q <= write_i;
                wdata_q <= wdata_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fire_i) begin
                    state_d = (route_i == RT_MEM) ? ST_MEM : ST_RESP;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            ST_MEM: begin
                if (mem_ack_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready_o     = 1'b0;
        reg_wr_o    = 1'b0;
        done_o      = 1'b0;
        mem_done_o  = 1'b0;
        trap_o      = 1'b0;
        undef_o     = 1'b0;
        class_o     = '0;
        rdata_o     = '0;
        mem_valid_o = 1'b0;
        mem_write_o = 1'b0;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                ready_o  = 1'b1;
                reg_wr_o = fire_i && write_i && (route_i == RT_DIRECT);
            end
            ST_RESP: begin
                done_o  = (kind_q == RT_DIRECT);
                trap_o  = (kind_q == RT_TRAP);
                undef_o = (kind_q == RT_UNDEF);
                if (kind_q == RT_TRAP) begin
                    class_o = TRAP_CLASS;
                end
                if (kind_q == RT_DIRECT) begin
                    rdata_o = readback_i;
                end
            end
            ST_MEM: begin
                mem_valid_o = 1'b1;
                mem_write_o = write_q;
                mem_wdata_o = wdata_q;
                mem_done_o  = mem_ack_i;
                rdata_o     = mem_rdata_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nvreg_redirect.sv
module nvreg_redirect
    import nvr_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int PAGE_BITS  = 12,
    parameter int NARROW_MSB = 48,
    parameter int WIDE_MSB   = 52,
    parameter int CLASS_W    = 6,
    parameter logic [PAGE_BITS-1:0] OFFSET     = 12'h0B0,
    parameter logic [CLASS_W-1:0]   TRAP_CLASS = 6'h18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op0,
    input  logic [2:0]         req_op1,
    input  logic [3:0]         req_crn,
    input  logic [3:0]         req_crm,
    input  logic [2:0]         req_op2,
    input  logic               req_write,
    input  logic [XLEN-1:0]    req_wdata,
    input  logic [1:0]         cur_el,
    input  logic               el2_en,
    input  logic               ctl_nv,
    input  logic               ctl_nv2,
    input  logic               va_wide,
    output logic               res_done,
    output logic               res_mem,
    output logic               res_trap,
    output logic               res_undef,
    output logic [CLASS_W-1:0] res_class,
    output logic [XLEN-1:0]    res_rdata,
    output logic               mem_valid,
    output logic               mem_write,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    mem_wdata,
    input  logic               mem_ack,
    input  logic [XLEN-1:0]    mem_rdata
);

    sysenc_t         enc;
    logic            hit;
    route_t          route;
    logic            reg_wr;
    logic [XLEN-1:0] readback;

    assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};

    nvr_decode u_decode (
        .enc_i    (enc),
        .el_i     (cur_el),
        .el2_en_i (el2_en),
        .nv_i     (ctl_nv),
        .nv2_i    (ctl_nv2),
        .hit_o    (hit),
        .route_o  (route)
    );

    nvr_basereg #(
        .XLEN       (XLEN),
        .PAGE_BITS  (PAGE_BITS),
        .NARROW_MSB (NARROW_MSB),
        .WIDE_MSB   (WIDE_MSB),
        .OFFSET     (OFFSET)
    ) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_wr),
        .wr_base_i  (req_wdata[XLEN-1:PAGE_BITS]),
        .va_wide_i  (va_wide),
        .readback_o (readback),
        .addr_o     (mem_addr)
    );

    nvr_ctrl #(
        .XLEN       (XLEN),
        .CLASS_W    (CLASS_W),
        .TRAP_CLASS (TRAP_CLASS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (req_valid && hit),
        .route_i     (route),
        .write_i     (req_write),
        .wdata_i     (req_wdata),
        .readback_i  (readback),
        .mem_ack_i   (mem_ack),
        .mem_rdata_i (mem_rdata),
        .ready_o     (req_ready),
        .reg_wr_o    (reg_wr),
        .done_o      (res_done),
        .mem_done_o  (res_mem),
        .trap_o      (res_trap),
        .undef_o     (res_undef),
        .class_o     (res_class),
        .rdata_o     (res_rdata),
        .mem_valid_o (mem_valid),
        .mem_write_o (mem_write),
        .mem_wdata_o (mem_wdata)
    );

endmodule

// File: rtl/nvr_chk.sv
module nvr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_op0,
    input logic [2:0]  req_op1,
    input logic [3:0]  req_crn,
    input logic [3:0]  req_crm,
    input logic [2:0]  req_op2,
    input logic [1:0]  cur_el,
    input logic        el2_en,
    input logic        ctl_nv,
    input logic        ctl_nv2,
    input logic        va_wide,
    input logic        res_done,
    input logic        res_mem,
    input logic        res_trap,
    input logic        res_undef,
    input logic [5:0]  res_class,
    input logic [63:0] res_rdata,
    input logic        mem_valid,
    input logic        mem_write,
    input logic [63:0] mem_addr,
    input logic [63:0] mem_wdata,
    input logic        mem_ack
);

    logic accept;
    assign accept = req_valid && req_ready && req_op0 == 2'b11 && req_op1 == 3'b100 &&
                    req_crn == 4'b0010 && req_crm == 4'b0010 && req_op2 == 3'b000;

    // R10
    result_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_done, res_mem, res_trap, res_undef}));

    // R10
    class_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_trap |-> res_class == 6'h18) and (!res_trap |-> res_class == 6'h00));

    // R2
    user_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_el == 2'd0) |=> res_undef);

    // R4
    guest_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_el == 2'd1 && el2_en && ctl_nv && !ctl_nv2) |=> res_trap);

    // R3
    guest_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_el == 2'd1 && el2_en && ctl_nv && ctl_nv2) |=> mem_valid);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_write) && $stable(mem_wdata)));

    // R9
    mem_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ack) |=> !mem_valid);

    // R8
    addr_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[11:0] == 12'h0B0);

    // R8
    addr_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !va_wide) |-> ($countones(mem_addr[63:48]) == 0 || $countones(mem_addr[63:48]) == 16));

    // R7
    readback_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> res_rdata[11:0] == 12'h000);

    // R12
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || res_done || res_trap || res_undef) |-> !req_ready);

endmodule

bind nvreg_redirect nvr_chk u_chk (.*);

// File: tb/tb_nvreg_redirect.sv
module tb_nvreg_redirect;

    localparam int K_DIR = 0, K_MEM = 1, K_TRAP = 2, K_UND = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_op0 = 2'b11;
    logic [2:0]  req_op1 = 3'b100;
    logic [3:0]  req_crn = 4'b0010, req_crm = 4'b0010;
    logic [2:0]  req_op2 = 3'b000;
    logic [63:0] req_wdata = '0;
    logic [1:0]  cur_el = 2'd2;
    logic        el2_en = 1'b0, ctl_nv = 1'b0, ctl_nv2 = 1'b0, va_wide = 1'b0;
    logic        req_ready, res_done, res_mem, res_trap, res_undef;
    logic [5:0]  res_class;
    logic [63:0] res_rdata, mem_addr, mem_wdata;
    logic        mem_valid, mem_write;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int    total = 0, bad = 0, ack_delay = 0, wait_cnt = 0;
    string cur_tag = "R11";
    logic [63:0] last_rdata = '0, last_addr = '0, last_wdata = '0;
    logic [63:0] rdata_pat = 64'hC0DE_0000_0000_0001;

    always #10 clk = ~clk;

    nvreg_redirect dut (.*);

    // behavioural reference
    int          m_phase = 0, m_kind = K_UND;
    logic [63:0] m_reg = '0, m_wd = '0;
    logic        m_wr = 1'b0;

    function automatic int route_of(logic [1:0] el, logic en, logic nv, logic nv2);
        if (el == 2'd0) return K_UND;
        if (el >= 2'd2) return K_DIR;
        if (en && nv && nv2) return K_MEM;
        if (en && nv) return K_TRAP;
        return K_UND;
    endfunction

    function automatic logic [63:0] exp_addr(logic [63:0] r, logic wide);
        if (wide) return {{11{r[52]}}, r[52:12], 12'h0B0};
        return {{15{r[48]}}, r[48:12], 12'h0B0};
    endfunction

    always @(posedge clk) begin : model
        int k;
        if (!rst_n) begin
            m_phase <= 0;
            m_reg   <= '0;
        end else if (m_phase == 0) begin
            if (req_valid && req_op0 == 2'b11 && req_op1 == 3'b100 && req_crn == 4'b0010 &&
                req_crm == 4'b0010 && req_op2 == 3'b000) begin
                k = route_of(cur_el, el2_en, ctl_nv, ctl_nv2);
                m_kind <= k;
                m_wr   <= req_write;
                m_wd   <= req_wdata;
                if (k == K_DIR && req_write) m_reg <= {req_wdata[63:12], 12'h000};
                m_phase <= (k == K_MEM) ? 2 : 1;
            end
        end else if (m_phase == 1) begin
            m_phase <= 0;
        end else if (mem_ack) begin
            m_phase <= 0;
        end
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R11", "ready in reset", 64'(req_ready), 64'd1);
            chk("R11", "no result in reset", 64'({res_done, res_mem, res_trap, res_undef, mem_valid}), 64'd0);
        end else begin
            chk("R12", "ready", 64'(req_ready), 64'(m_phase == 0));
            chk(cur_tag, "done", 64'(res_done), 64'(m_phase == 1 && m_kind == K_DIR));
            chk(cur_tag, "trap", 64'(res_trap), 64'(m_phase == 1 && m_kind == K_TRAP));
            chk(cur_tag, "undef", 64'(res_undef), 64'(m_phase == 1 && m_kind == K_UND));
            chk(cur_tag, "mem done", 64'(res_mem), 64'(m_phase == 2 && mem_ack));
            chk("R10", "class", 64'(res_class), (m_phase == 1 && m_kind == K_TRAP) ? 64'h18 : 64'h0);
            chk("R9", "mem_valid", 64'(mem_valid), 64'(m_phase == 2));
            if (m_phase == 2) begin
                chk("R8", "addr", mem_addr, exp_addr(m_reg, va_wide));
                chk("R3", "mem_write", 64'(mem_write), 64'(m_wr));
                chk("R3", "mem_wdata", mem_wdata, m_wd);
                last_addr  = mem_addr;
                last_wdata = mem_wdata;
                if (mem_ack) begin
                    chk("R9", "load data", res_rdata, mem_rdata);
                    last_rdata = res_rdata;
                end
            end
            if (m_phase == 1 && m_kind == K_DIR) begin
                chk("R6", "readback", res_rdata, m_reg);
                last_rdata = res_rdata;
            end
        end
    end

    // memory responder
    initial begin
        forever begin
            @(posedge clk);
            #4;
            if (mem_valid && !mem_ack) begin
                if (wait_cnt >= ack_delay) begin
                    mem_ack   = 1'b1;
                    mem_rdata = rdata_pat;
                end else begin
                    wait_cnt++;
                end
            end else begin
                mem_ack  = 1'b0;
                wait_cnt = 0;
            end
        end
    end

    task automatic send(string tag, logic [1:0] el, logic en, logic nv, logic nv2, logic wide,
                        logic wr, logic [63:0] wd, logic [2:0] op2 = 3'b000);
        cur_tag   = tag;
        cur_el    = el;
        el2_en    = en;
        ctl_nv    = nv;
        ctl_nv2   = nv2;
        va_wide   = wide;
        req_write = wr;
        req_wdata = wd;
        req_op2   = op2;
        req_valid = 1'b1;
        @(posedge clk);
        #4;
        req_valid = 1'b0;
        req_op2   = 3'b000;
    endtask

    task automatic settle();
        while (!req_ready) begin
            @(posedge clk);
            #4;
        end
        @(posedge clk);
        #4;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #4;
        rst_n = 1'b1;
        @(posedge clk);
        #4;

        // R11: register starts at zero
        send("R11", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0); settle();
        chk("R11", "reset value", last_rdata, 64'h0);

        // R6 / R7: direct write at level 2, read at level 3
        send("R6", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0001_8000_0000_0FFF); settle();
        send("R7", 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0); settle();
        chk("R7", "low bits cleared", last_rdata, 64'h0001_8000_0000_0000);

        // R1: mismatched encoding ignored
        send("R1", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'hDEAD_BEEF_0000_0000, 3'b001); settle();
        send("R1", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0); settle();
        chk("R1", "unchanged after other encoding", last_rdata, 64'h0001_8000_0000_0000);

        // R2: level 0
        send("R2", 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0); settle();
        send("R2", 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 64'h5); settle();

        // R4 / R5: level 1 routing combinations
        send("R4", 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0); settle();
        send("R4", 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 64'h7); settle();
        send("R5", 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0); settle();
        send("R5", 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 64'h9); settle();
        send("R5", 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0); settle();

        // R3 / R8 / R9: redirected load, narrow space, delayed ack
        ack_delay = 3;
        rdata_pat = 64'hC0DE_1111_2222_3333;
        send("R9", 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0); settle();
        chk("R8", "narrow address", last_addr, 64'hFFFF_8000_0000_00B0);
        chk("R9", "load data returned", last_rdata, 64'hC0DE_1111_2222_3333);

        // R3 / R8 / R12: redirected store, wide space, direct write during wait
        ack_delay = 5;
        send("R3", 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 64'h1122_3344_5566_7788);
        send("R12", 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'hAAAA_AAAA_AAAA_A000); settle();
        chk("R8", "wide address", last_addr, 64'h0001_8000_0000_00B0);
        chk("R3", "store data", last_wdata, 64'h1122_3344_5566_7788);
        send("R12", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0); settle();
        chk("R12", "write while busy ignored", last_rdata, 64'h0001_8000_0000_0000);

        // R8: bit 52 set, bit 48 clear; ack in the same cycle
        ack_delay = 0;
        send("R6", 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'hFFF0_0000_0000_0123); settle();
        send("R8", 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0); settle();
        chk("R8", "narrow from bit 48", last_addr, 64'h0000_0000_0000_00B0);
        send("R8", 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0); settle();
        chk("R8", "wide from bit 52", last_addr, 64'hFFF0_0000_0000_00B0);

        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule